// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block is a single-channel pulse-width modulator that software drives through a small word-addressed register interface. A control word sets enable, a clock prescaler, output polarity, a stored clock-select field and four stored run-enable flags. A period register fixes the length of one modulation period. Duty values are written into a four-entry queue instead of straight into the comparator. A prescaled counter sweeps each period, and the output is active while the counter is below the current compare value.

A new compare value is taken from the queue when the channel is switched on and at every period rollover. If the queue is empty, the previous value stays in use. Software watches the queue fill level in a status register, so it can keep the queue topped up one period ahead. Setting the reset bit of the control word clears the whole block. That bit reads back as set until the clear has finished.

Top module: `fpwm_top`

## Requirements
- R1: After the reset input, the control, status and period registers read 0 and `pwm_out` is 0.
- R2: Register offsets are control 0x00, status 0x04, sample queue write port 0x0C and period 0x10. In the control word these bits are stored and read back: bit 0 enable, bits 15:4 prescaler, bits 17:16 clock select, bit 18 polarity invert, and bits 25:22 run flags. All other bits read 0, and bit 3 also reads 0 whenever no soft reset is in progress.
- R3: While enabled, the period counter advances once every (prescaler field + 1) clocks.
- R4: The period counter counts from 0 to P+1, where P is the period register, so one period lasts P+2 prescaled ticks.
- R5: Before polarity is applied, the output is active while counter < compare value. A compare value of 0 never drives it active, and a value of P+2 or more keeps it active for the whole period.
- R6: When control bit 18 is set, the output is inverted. This applies both while running and while idle.
- R7: The queue holds up to 4 samples, and status bits 2:0 give its fill level. A sample written while the level is 4 is discarded.
- R8: When enable goes from 0 to 1 through a control write, and at each period rollover, the oldest queued sample becomes the compare value if the queue is not empty. Otherwise the compare value is kept.
- R9: While enable is 0, the counter and prescaler are held at 0 and `pwm_out` equals the polarity bit.
- R10: A control write with bit 3 set clears every register and empties the queue. Control bit 3 then reads 1 for SRST_CYCLES clocks and returns to 0. Register writes made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Modulated output after polarity |

## Verification
The hardest case to reach from the ports is the handoff at a period boundary. There the compare value must change on exactly the cycle the counter wraps, and the queue must run dry so that the last sample is reused. The bench sweeps every combination of small period values, prescaler ratios and polarity. For each combination it preloads three samples: one of them zero, one at or beyond the period length, and one in between. It then compares the output on every clock for five periods against a position computed from the clock count. A queue loaded with four zero samples plus a fifth non-zero one shows at the output whether the overflowing write was really dropped.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    localparam int ADDR_W  = 5;
    localparam int BUS_W   = 32;
    localparam int PRE_W   = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_SAMP = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PER  = 5'h10;

    localparam int SRST_BIT = 3;

    typedef struct packed {
        logic [3:0]       run_flags;
        logic             invert;
        logic [1:0]       clk_sel;
        logic [PRE_W-1:0] prediv;
        logic             enable;
    } ctrl_t;

    function automatic logic [BUS_W-1:0] ctrl_to_word(ctrl_t c);
        logic [BUS_W-1:0] w;
        w        = '0;
        w[0]     = c.enable;
        w[15:4]  = c.prediv;
        w[17:16] = c.clk_sel;
        w[18]    = c.invert;
        w[25:22] = c.run_flags;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [BUS_W-1:0] w);
        ctrl_t c;
        c.enable    = w[0];
        c.prediv    = w[15:4];
        c.clk_sel   = w[17:16];
        c.invert    = w[18];
        c.run_flags = w[25:22];
        return c;
    endfunction

endpackage

// File: rtl/fpwm_fifo.sv
module fpwm_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [LVL_W-1:0] level
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] slot;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [LVL_W-1:0]            lvl;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic do_push, do_pop;

    assign do_push = push && (s_q.lvl != LVL_W'(DEPTH));
    assign do_pop  = pop && (s_q.lvl != '0);

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.slot[s_q.wr] = push_data;
            s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        if (do_push && !do_pop)      s_d.lvl = s_q.lvl + 1'b1;
        else if (do_pop && !do_push) s_d.lvl = s_q.lvl - 1'b1;
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pop_data = s_q.slot[s_q.rd];
    assign level    = s_q.lvl;

    // R7: fill level never exceeds the queue depth
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R7: a write into a full queue without a pop leaves it full, not wrapped
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH) && push && !pop && !clr) |=> level == LVL_W'(DEPTH));

    // R10: clearing leaves the queue empty
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> level == '0);

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PRE_W-1:0] prediv,
    input  logic [CNT_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             invert,
    output logic             wrap,
    output logic             pwm_out
);

    typedef struct packed {
        logic [PRE_W-1:0] pdiv;
        logic [CNT_W:0]   cnt;
        logic [CNT_W-1:0] cmp;
    } tmr_st_t;

    tmr_st_t s_q, s_d;
    logic          tick;
    logic [CNT_W:0] last;

    assign last = {1'b0, period} + (CNT_W + 1)'(1);
    assign tick = en && (s_q.pdiv == prediv);
    assign wrap = tick && (s_q.cnt >= last);

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.pdiv = '0;
            s_d.cnt  = '0;
        end else if (tick) begin
            s_d.pdiv = '0;
            s_d.cnt  = wrap ? '0 : s_q.cnt + 1'b1;
        end else begin
            s_d.pdiv = s_q.pdiv + 1'b1;
        end
        if (load) s_d.cmp = cmp_in;
        if (clr)  s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_out = (en && (s_q.cnt < {1'b0, s_q.cmp})) ^ invert;

    // R9: a disabled timer holds counter and prescaler at zero
    a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.cnt == '0 && s_q.pdiv == '0));

    // R4: a rollover restarts the count from zero
    a_r4_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !clr) |=> s_q.cnt == '0);

    // R3: the counter only moves on a prescaler tick
    a_r3_stall_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !clr) |=> $stable(s_q.cnt));

    // R5: a zero compare value never drives the output active
    a_r5_zero_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmp == '0) |-> pwm_out == invert);

endmodule

// File: rtl/fpwm_top.sv
module fpwm_top
    import fpwm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int SRST_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              pwm_out
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam int SR_W  = $clog2(SRST_CYCLES + 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
        logic [SR_W-1:0]  busy_cnt;
    } top_st_t;

    top_st_t s_q, s_d;

    logic             busy, wr_ctrl, wr_per, wr_samp, srst_req, start_en;
    logic             clr, wrap, pop;
    logic [LVL_W-1:0] level;
    logic [CNT_W-1:0] head;

    assign busy     = (s_q.busy_cnt != '0);
    assign wr_ctrl  = bus_we && !busy && (bus_addr == OFS_CTRL);
    assign wr_per   = bus_we && !busy && (bus_addr == OFS_PER);
    assign wr_samp  = bus_we && !busy && (bus_addr == OFS_SAMP);
    assign srst_req = wr_ctrl && bus_wdata[SRST_BIT];
    assign start_en = wr_ctrl && !srst_req && bus_wdata[0] && !s_q.ctrl.enable;
    assign clr      = srst_req || busy;
    assign pop      = (start_en || wrap) && (level != '0);

    always_comb begin
        s_d = s_q;
        if (busy) begin
            s_d.busy_cnt = s_q.busy_cnt - 1'b1;
        end else if (srst_req) begin
            s_d          = '0;
            s_d.busy_cnt = SR_W'(SRST_CYCLES);
        end else begin
            if (wr_ctrl) s_d.ctrl   = word_to_ctrl(bus_wdata);
            if (wr_per)  s_d.period = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    fpwm_fifo #(.WIDTH(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (wr_samp),
        .push_data (bus_wdata[CNT_W-1:0]),
        .pop       (pop),
        .pop_data  (head),
        .level     (level)
    );

    fpwm_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (s_q.ctrl.enable),
        .prediv  (s_q.ctrl.prediv),
        .period  (s_q.period),
        .load    (pop),
        .cmp_in  (head),
        .invert  (s_q.ctrl.invert),
        .wrap    (wrap),
        .pwm_out (pwm_out)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_to_word(s_q.ctrl) | (BUS_W'(busy) << SRST_BIT);
            OFS_STAT: bus_rdata = BUS_W'(level);
            OFS_PER:  bus_rdata = BUS_W'(s_q.period);
            default:  bus_rdata = '0;
        endcase
    end

    // R10: while the soft reset runs, registers and queue stay cleared
    a_r10_busy_regs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.ctrl == '0 && s_q.period == '0 && level == '0));

    // R10: register writes made during soft reset do not land
    a_r10_writes_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |=> s_q.period == '0);

    // R9/R6: a disabled channel rests at the polarity level
    a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ctrl.enable |-> pwm_out == s_q.ctrl.invert);

endmodule

// File: tb/fpwm_top_tb.sv
module fpwm_top_tb;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_SAMP = 5'h0C;
    localparam logic [4:0] A_PER  = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    fpwm_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic soft_reset();
        wr(A_CTRL, 32'h8);
        repeat (5) @(negedge clk);
    endtask

    function automatic logic exp_out(int t, int p, int dv, int inv, int s0, int s1, int s2);
        int per, k, j, s;
        per = p + 2;
        k = (t / dv) % per;
        j = t / (dv * per);
        s = (j == 0) ? s0 : ((j == 1) ? s1 : s2);
        return logic'((k < s) ? 1 : 0) ^ logic'(inv);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, r); check("R1 ctrl", r, 32'h0);
        rd(A_STAT, r); check("R1 status", r, 32'h0);
        rd(A_PER, r);  check("R1 period", r, 32'h0);
        check("R1 out", 32'(pwm_out), 32'h0);

        // R2: stored control fields, bit 3 and unused bits read 0
        wr(A_CTRL, 32'hFFFF_FFF6);
        rd(A_CTRL, r); check("R2 ctrl mask", r, 32'h03C7_FFF0);
        wr(A_PER, 32'h0001_ABCD);
        rd(A_PER, r);  check("R2 period width", r, 32'h0000_ABCD);
        rd(5'h08, r);  check("R2 unmapped", r, 32'h0);
        wr(A_CTRL, 32'h0);

        // R10: soft reset clears, bit 3 busy, writes ignored
        soft_reset();
        wr(A_PER, 32'd7);
        wr(A_SAMP, 32'd2);
        wr(A_SAMP, 32'd3);
        wr(A_CTRL, 32'h0004_0001);
        wr(A_CTRL, 32'h0000_0008);
        rd(A_CTRL, r); check("R10 busy readback", r, 32'h8);
        rd(A_STAT, r); check("R10 queue emptied", r, 32'h0);
        rd(A_PER, r);  check("R10 period cleared", r, 32'h0);
        wr(A_PER, 32'd9);
        repeat (4) @(negedge clk);
        rd(A_CTRL, r); check("R10 bit clears", r, 32'h0);
        rd(A_PER, r);  check("R10 write during busy ignored", r, 32'h0);
        check("R10 out idle", 32'(pwm_out), 32'h0);

        // R7: fill level and overflow drop
        for (int i = 1; i <= 5; i++) begin
            wr(A_SAMP, (i == 5) ? 32'd5 : 32'd0);
            rd(A_STAT, r);
            check($sformatf("R7 level after %0d writes", i), r, 32'((i > 4) ? 4 : i));
        end
        wr(A_PER, 32'd0);
        wr(A_CTRL, 32'h1);
        begin
            int hi = 0;
            for (int t = 0; t < 16; t++) begin
                if (pwm_out) hi++;
                @(negedge clk);
            end
            check("R7 overflow sample discarded", 32'(hi), 32'd0);
        end
        soft_reset();

        // R3 R4 R5 R6 R8 R9: sweep over period, prescale, polarity
        for (int p = 0; p < 4; p++) begin
            for (int pre = 0; pre < 3; pre++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    int s0, s1, s2, dv, mism, ncyc;
                    dv = pre + 1;
                    s0 = p + 1; s1 = 0; s2 = p + 2 + inv;
                    wr(A_PER, 32'(p));
                    wr(A_SAMP, 32'(s0));
                    wr(A_SAMP, 32'(s1));
                    wr(A_SAMP, 32'(s2));
                    wr(A_CTRL, 32'(pre << 4) | 32'(inv << 18) | 32'h1);
                    rd(A_STAT, r);
                    check($sformatf("R8 pop on enable p=%0d dv=%0d inv=%0d", p, dv, inv), r, 32'd2);
                    mism = 0;
                    ncyc = 5 * dv * (p + 2);
                    for (int t = 0; t < ncyc; t++) begin
                        if (pwm_out !== exp_out(t, p, dv, inv, s0, s1, s2)) begin
                            if (mism == 0)
                                $display("FAIL R5 cycle %0d p=%0d dv=%0d inv=%0d actual=%0b expected=%0b",
                                         t, p, dv, inv, pwm_out, exp_out(t, p, dv, inv, s0, s1, s2));
                            mism++;
                        end
                        @(negedge clk);
                    end
                    check($sformatf("R3/R4/R5/R6 waveform p=%0d dv=%0d inv=%0d", p, dv, inv), 32'(mism), 32'd0);
                    rd(A_STAT, r);
                    check($sformatf("R8 queue drained p=%0d dv=%0d inv=%0d", p, dv, inv), r, 32'd0);
                    wr(A_CTRL, 32'(inv << 18));
                    begin
                        int off_bad = 0;
                        for (int t = 0; t < 4; t++) begin
                            if (pwm_out !== logic'(inv)) off_bad++;
                            @(negedge clk);
                        end
                        check($sformatf("R9/R6 idle level inv=%0d", inv), 32'(off_bad), 32'd0);
                    end
                    soft_reset();
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule